// File: doc/BRIEF.md
# SPI Slave with Buffer Descriptors

This block is a slave-only serial peripheral port that moves 8-bit characters between the four serial wires and two one-entry buffer descriptors held inside the block. One descriptor receives and one transmits. Each has a flag (receive empty, transmit ready), a programmed length and local byte storage. The two descriptors close independently of each other. The receive side closes on deselect, or on the first byte that no longer fits. The transmit side closes once its programmed number of bytes has been shifted out.

Software fills the transmit storage and programs both lengths through a small register port. It then sets the receive-empty and transmit-ready flags together with a start strobe. After the transfer it reads the received bytes and the received count. Three events report what happened: receive closed, transmit closed and out-of-buffers. They sit in a write-one-to-clear register that is masked onto a single interrupt line. The serial clock, select and data input are brought into the system clock with two-flop synchronisers. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_bd_slave`

## Requirements
- R1: After reset the control register (address 0x00) and the event register (address 0x01) read 0, irq is low and spi_miso is high.
- R2: Receive uses mode 0, most significant bit first: spi_mosi is sampled on rising spi_sck. The n-th stored byte reads back at address 0x20+n.
- R3: Writing 1 to control bit 2 (start) arms the block only if, after the same write, bit 0 (receive empty) and bit 1 (transmit ready) are both 1. An armed block reads 1 in control bit 2. Bytes that arrive while the block is not armed are not stored and raise no event.
- R4: Negating spi_ssel_n on an open receive descriptor closes it with the count received so far. The count reads at address 0x03. The close sets event bit 0 and clears control bit 0. A transmit descriptor that has not finished stays open (control bit 1 stays 1).
- R5: Transmit bytes written at address 0x10+n go out on spi_miso most significant bit first, changing after falling spi_sck. Once the count programmed at address 0x05 (1 to 16) has been sent, the transmit descriptor closes even if select is still low. The close sets event bit 1 and clears control bit 1.
- R6: With receive length L at address 0x04, exactly L bytes followed by deselect close the receive descriptor with count L and no event bit 2. The byte L+1 is discarded and in the same cycle sets event bit 2 (out-of-buffers) and closes the receive descriptor with count L.
- R7: While the transmit descriptor is closed or not ready, spi_miso sends 0xFF bytes.
- R8: Writing ones to the event register clears those bits. An event raised in the same cycle as its clear stays set.
- R9: irq is high exactly when some event bit is set whose bit in the mask register (address 0x02) is 1.
- R10: Re-arming resets the receive count and the transmit position to zero. The block disarms once both descriptors are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| spi_sck | input | 1 | Serial clock from the master |
| spi_ssel_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| irq | output | 1 | Masked event interrupt |

## Verification
The two things that share a cycle here are the overflow event and the receive close. Both come from the completion of byte L+1, and they must appear together with the count frozen at L. The bench provokes this by sweeping the receive length, transmit length and byte count over small ranges. Each result is judged against an arithmetic prediction of the event bits, the count and the transmit flag. Longer transfers also close the transmit descriptor in the middle of a transfer, in the same window. The priority of a hardware event over a clear written in the same cycle is guarded by an assertion beside the event register.

// File: rtl/spibd_pkg.sv
`timescale 1ns/1ps
package spibd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned EV_W   = 3;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [REG_AW-1:0] A_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] A_EVENT = 6'h01;
  localparam logic [REG_AW-1:0] A_MASK  = 6'h02;
  localparam logic [REG_AW-1:0] A_RXCNT = 6'h03;
  localparam logic [REG_AW-1:0] A_RXLEN = 6'h04;
  localparam logic [REG_AW-1:0] A_TXLEN = 6'h05;
  localparam logic [1:0] RGN_TXBUF = 2'b01;
  localparam logic [1:0] RGN_RXBUF = 2'b10;

  localparam int unsigned EV_RX  = 0;
  localparam int unsigned EV_TX  = 1;
  localparam int unsigned EV_OOB = 2;
endpackage

// File: rtl/spibd_sync.sv
`timescale 1ns/1ps
module spibd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ssel_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_start,
  output logic sel_end,
  output logic sel_on,
  output logic mosi_o
);
  localparam int unsigned W = 3;
  localparam logic [W-1:0] IDLE = 3'b010;

  logic [W-1:0] chain_q [STAGES];
  logic [1:0]   hist_q;
  logic [W-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= IDLE;
      hist_q <= IDLE[1:0];
    end else begin
      chain_q[0] <= {mosi_i, ssel_n_i, sck_i};
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      hist_q <= chain_q[STAGES-1][1:0];
    end
  end

  always_comb begin
    cur       = chain_q[STAGES-1];
    sck_rise  =  cur[0] & ~hist_q[0];
    sck_fall  = ~cur[0] &  hist_q[0];
    sel_start = ~cur[1] &  hist_q[1];
    sel_end   =  cur[1] & ~hist_q[1];
    sel_on    = ~cur[1];
    mosi_o    =  cur[2];
  end
endmodule

// File: rtl/spibd_shifter.sv
`timescale 1ns/1ps
module spibd_shifter
  import spibd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  sel_start,
  input  logic  sel_on,
  input  logic  mosi,
  input  byte_t load_byte,
  output logic  miso,
  output byte_t rx_byte,
  output logic  byte_done
);
  localparam int unsigned CW = $clog2(BYTE_W);

  logic [CW-1:0] bit_q, bit_d;
  byte_t rxs_q, rxs_d, txs_q, txs_d, rxb_q, rxb_d;
  logic  done_q, done_d;

  always_comb begin
    bit_d  = bit_q;
    rxs_d  = rxs_q;
    txs_d  = txs_q;
    rxb_d  = rxb_q;
    done_d = 1'b0;
    if (!sel_on) begin
      bit_d = '0;
    end else if (sck_rise) begin
      rxs_d = {rxs_q[BYTE_W-2:0], mosi};
      bit_d = bit_q + 1'b1;
      if (bit_q == CW'(BYTE_W-1)) begin
        rxb_d  = rxs_d;
        done_d = 1'b1;
      end
    end
    if (sel_start) begin
      txs_d = load_byte;
    end else if (sel_on && sck_fall) begin
      if (bit_q == '0) txs_d = load_byte;
      else             txs_d = {txs_q[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rxs_q  <= '0;
      txs_q  <= '1;
      rxb_q  <= '0;
      done_q <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      rxs_q  <= rxs_d;
      txs_q  <= txs_d;
      rxb_q  <= rxb_d;
      done_q <= done_d;
    end
  end

  assign miso      = txs_q[BYTE_W-1];
  assign rx_byte   = rxb_q;
  assign byte_done = done_q;

  // R2: a completed byte always follows a sampled rising clock edge
  a_r2_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(sck_rise));
  // R5: inside a byte each falling edge moves the next lower bit onto the line
  a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_on && sck_fall && !sel_start && bit_q != '0) |=> (miso == $past(txs_q[BYTE_W-2])));
endmodule

// File: rtl/spibd_desc.sv
`timescale 1ns/1ps
module spibd_desc
  import spibd_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  byte_t         rx_byte,
  input  logic          sel_end,
  input  logic          sw_rx_empty,
  input  logic          sw_tx_ready,
  input  logic          sw_start,
  input  byte_t         rx_len,
  input  byte_t         tx_len,
  input  logic          tx_we,
  input  logic [IW-1:0] tx_widx,
  input  byte_t         tx_wdata,
  input  logic [IW-1:0] rd_idx,
  output byte_t         rd_data,
  output byte_t         tx_next,
  output logic          rx_empty,
  output logic          tx_ready,
  output logic          armed,
  output byte_t         rx_count,
  output logic          ev_rx,
  output logic          ev_tx,
  output logic          ev_oob
);
  byte_t rxm [DEPTH];
  byte_t txm [DEPTH];

  byte_t rx_lim, tx_lim;
  byte_t rx_cnt_q, rx_cnt_d, tx_pos_q, tx_pos_d;
  logic  rx_empty_q, rx_empty_d, tx_ready_q, tx_ready_d, armed_q, armed_d;
  logic  rx_open, tx_open, rx_wr, rx_close, tx_close, oob;

  always_comb begin
    rx_lim = (rx_len > byte_t'(DEPTH)) ? byte_t'(DEPTH) : rx_len;
    tx_lim = (tx_len > byte_t'(DEPTH)) ? byte_t'(DEPTH) : tx_len;
  end

  always_comb begin
    rx_open    = armed_q & rx_empty_q;
    tx_open    = armed_q & tx_ready_q;
    rx_cnt_d   = rx_cnt_q;
    tx_pos_d   = tx_pos_q;
    rx_empty_d = rx_empty_q;
    tx_ready_d = tx_ready_q;
    armed_d    = armed_q;
    rx_wr      = 1'b0;
    rx_close   = 1'b0;
    tx_close   = 1'b0;
    oob        = 1'b0;
    // receive side
    if (byte_done && rx_open) begin
      if (rx_cnt_q < rx_lim) begin
        rx_wr    = 1'b1;
        rx_cnt_d = rx_cnt_q + 1'b1;
      end else begin
        oob      = 1'b1;
        rx_close = 1'b1;
      end
    end
    if (sel_end && rx_open) rx_close = 1'b1;
    if (rx_close) rx_empty_d = 1'b0;
    // transmit side
    if (byte_done && tx_open) begin
      tx_pos_d = tx_pos_q + 1'b1;
      if (tx_pos_d >= tx_lim) begin
        tx_ready_d = 1'b0;
        tx_close   = 1'b1;
      end
    end
    // software reuse
    if (sw_rx_empty) begin
      rx_empty_d = 1'b1;
      rx_cnt_d   = '0;
    end
    if (sw_tx_ready) begin
      tx_ready_d = 1'b1;
      tx_pos_d   = '0;
    end
    if (sw_start && rx_empty_d && tx_ready_d) armed_d = 1'b1;
    else if (!rx_empty_d && !tx_ready_d)      armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt_q   <= '0;
      tx_pos_q   <= '0;
      rx_empty_q <= 1'b0;
      tx_ready_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      rx_cnt_q   <= rx_cnt_d;
      tx_pos_q   <= tx_pos_d;
      rx_empty_q <= rx_empty_d;
      tx_ready_q <= tx_ready_d;
      armed_q    <= armed_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_wr) rxm[rx_cnt_q[IW-1:0]] <= rx_byte;
    if (tx_we) txm[tx_widx] <= tx_wdata;
  end

  always_comb begin
    rd_data = rxm[rd_idx];
    tx_next = (tx_open && tx_pos_q < tx_lim) ? txm[tx_pos_q[IW-1:0]] : '1;
  end

  assign rx_empty = rx_empty_q;
  assign tx_ready = tx_ready_q;
  assign armed    = armed_q;
  assign rx_count = rx_cnt_q;
  assign ev_rx    = rx_close;
  assign ev_tx    = tx_close;
  assign ev_oob   = oob;

  // R3: bytes arriving while disarmed leave the receive count untouched
  a_r3_idle_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !armed_q && !sw_rx_empty) |=> $stable(rx_cnt_q));
  // R4: deselect alone never closes the transmit descriptor
  a_r4_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_end && !byte_done && tx_ready_q) |=> tx_ready_q);
  // R5: a transmit close takes effect in the next cycle
  a_r5_tx_close: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx && !sw_tx_ready) |=> !tx_ready_q);
  // R6: the excess byte closes receive and leaves the count as it was
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_oob && !sw_rx_empty) |=> (!rx_empty_q && $stable(rx_cnt_q)));
  // R7: with no ready transmit descriptor only ones are offered
  a_r7_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready_q |-> (tx_next == '1));
endmodule

// File: rtl/spi_bd_slave.sv
`timescale 1ns/1ps
module spi_bd_slave
  import spibd_pkg::*;
#(
  parameter int unsigned BUF_DEPTH   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              spi_sck,
  input  logic              spi_ssel_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              irq
);
  localparam int unsigned IW = $clog2(BUF_DEPTH);

  logic sck_rise, sck_fall, sel_start, sel_end, sel_on, mosi_s;
  logic byte_done, rx_empty, tx_ready, armed, ev_rx, ev_tx, ev_oob;
  byte_t rx_byte, tx_next, rd_data, rx_count;
  byte_t rx_len_q, rx_len_d, tx_len_q, tx_len_d, mask_q, mask_d;
  logic [EV_W-1:0] ev_q, ev_d, ev_set, ev_clr;
  logic wr_ctrl, tx_we;
  logic [1:0] region;

  spibd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .ssel_n_i(spi_ssel_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel_start(sel_start), .sel_end(sel_end),
    .sel_on(sel_on), .mosi_o(mosi_s));

  spibd_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_start(sel_start), .sel_on(sel_on), .mosi(mosi_s), .load_byte(tx_next),
    .miso(spi_miso), .rx_byte(rx_byte), .byte_done(byte_done));

  always_comb begin
    region  = reg_addr[REG_AW-1 -: 2];
    wr_ctrl = reg_we && (reg_addr == A_CTRL);
    tx_we   = reg_we && (region == RGN_TXBUF);
  end

  spibd_desc #(.DEPTH(BUF_DEPTH)) u_desc (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte), .sel_end(sel_end),
    .sw_rx_empty(wr_ctrl & reg_wdata[0]), .sw_tx_ready(wr_ctrl & reg_wdata[1]),
    .sw_start(wr_ctrl & reg_wdata[2]), .rx_len(rx_len_q), .tx_len(tx_len_q),
    .tx_we(tx_we), .tx_widx(reg_addr[IW-1:0]), .tx_wdata(reg_wdata),
    .rd_idx(reg_addr[IW-1:0]), .rd_data(rd_data), .tx_next(tx_next),
    .rx_empty(rx_empty), .tx_ready(tx_ready), .armed(armed), .rx_count(rx_count),
    .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_oob(ev_oob));

  // configuration registers
  always_comb begin
    rx_len_d = rx_len_q;
    tx_len_d = tx_len_q;
    mask_d   = mask_q;
    if (reg_we) begin
      if (reg_addr == A_RXLEN) rx_len_d = reg_wdata;
      if (reg_addr == A_TXLEN) tx_len_d = reg_wdata;
      if (reg_addr == A_MASK)  mask_d   = reg_wdata;
    end
  end

  // event register: hardware set wins over a same-cycle clear
  always_comb begin
    ev_set            = '0;
    ev_set[EV_RX]     = ev_rx;
    ev_set[EV_TX]     = ev_tx;
    ev_set[EV_OOB]    = ev_oob;
    ev_clr            = (reg_we && reg_addr == A_EVENT) ? reg_wdata[EV_W-1:0] : '0;
    ev_d              = (ev_q & ~ev_clr) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_len_q <= byte_t'(BUF_DEPTH);
      tx_len_q <= byte_t'(BUF_DEPTH);
      mask_q   <= '0;
      ev_q     <= '0;
    end else begin
      rx_len_q <= rx_len_d;
      tx_len_q <= tx_len_d;
      mask_q   <= mask_d;
      ev_q     <= ev_d;
    end
  end

  assign irq = |(ev_q & mask_q[EV_W-1:0]);

  always_comb begin
    reg_rdata = '0;
    if (region == RGN_RXBUF) begin
      reg_rdata = rd_data;
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata = {{(BYTE_W-3){1'b0}}, armed, tx_ready, rx_empty};
        A_EVENT: reg_rdata = {{(BYTE_W-EV_W){1'b0}}, ev_q};
        A_MASK:  reg_rdata = mask_q;
        A_RXCNT: reg_rdata = rx_count;
        A_RXLEN: reg_rdata = rx_len_q;
        A_TXLEN: reg_rdata = tx_len_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  // R8: every raised event is visible in the following cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> ((ev_q & $past(ev_set)) == $past(ev_set)));
  // R9: an interrupt always has a cause that is still held
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ev_q != '0));
endmodule

// File: tb/sim_spi_bd_slave.sv
`timescale 1ns/1ps
module sim_spi_bd_slave;
  import spibd_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  byte_t reg_wdata = '0;
  byte_t reg_rdata;
  logic sck = 1'b0, ssel_n = 1'b1, mosi = 1'b0;
  logic miso, irq;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  byte_t txd [16];
  byte_t got [32];
  byte_t rv;

  always #2.5 clk = ~clk;

  spi_bd_slave u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(sck),
    .spi_ssel_n(ssel_n), .spi_mosi(mosi), .spi_miso(miso), .irq(irq));

  function automatic byte_t mpat(input int k, input int s);
    return byte_t'(8'hA5 ^ (k * 29) ^ s);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input byte_t d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output byte_t d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic sel_lo;
    @(negedge clk) ssel_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sel_hi;
    repeat (8) @(negedge clk);
    ssel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic xbyte(input byte_t mo, output byte_t mi);
    for (int b = 7; b >= 0; b--) begin
      mosi = mo[b];
      repeat (4) @(negedge clk);
      mi[b] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_bytes(input int first, input int n, input int seed);
    for (int k = first; k < first + n; k++) xbyte(mpat(k, seed), got[k]);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    bit ok;
    int cnt, expev;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, rv);  chk(rv == 8'h00, "R1 ctrl", rv, 0);
    rd(A_EVENT, rv); chk(rv == 8'h00, "R1 event", rv, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(miso == 1'b1, "R1 miso", miso, 1);

    for (int i = 0; i < 16; i++) begin
      txd[i] = byte_t'(8'h3C ^ (i * 37));
      wr(REG_AW'(8'h10 + i), txd[i]);
    end

    // R3 start refused without transmit ready; bytes ignored
    wr(A_CTRL, 8'h05);
    rd(A_CTRL, rv); chk(rv == 8'h01, "R3 start refused", rv, 8'h01);
    sel_lo(); run_bytes(0, 2, 9); sel_hi();
    rd(A_RXCNT, rv); chk(rv == 8'h00, "R3 nothing stored", rv, 0);
    rd(A_EVENT, rv); chk(rv == 8'h00, "R3 no event", rv, 0);
    rd(A_CTRL, rv);  chk(rv == 8'h01, "R3 still empty", rv, 8'h01);
    chk(got[0] == 8'hFF && got[1] == 8'hFF, "R7 not ready ones", got[0], 8'hFF);

    // R2 R4 R5 short transfer closed by deselect
    wr(A_RXLEN, 8'd16); wr(A_TXLEN, 8'd5); wr(A_CTRL, 8'h07);
    rd(A_CTRL, rv); chk(rv == 8'h07, "R10 armed", rv, 8'h07);
    sel_lo(); run_bytes(0, 3, 1); sel_hi();
    for (int k = 0; k < 3; k++) begin
      chk(got[k] == txd[k], "R5 miso byte", got[k], txd[k]);
      rd(REG_AW'(8'h20 + k), rv); chk(rv == mpat(k, 1), "R2 rx byte", rv, mpat(k, 1));
    end
    rd(A_RXCNT, rv); chk(rv == 8'd3, "R4 count", rv, 3);
    rd(A_EVENT, rv); chk(rv == 8'h01, "R4 event", rv, 1);
    rd(A_CTRL, rv);  chk(rv == 8'h06, "R4 tx stays open", rv, 8'h06);
    chk(irq == 1'b0, "R9 masked", irq, 0);
    wr(A_MASK, 8'h01); @(negedge clk);
    chk(irq == 1'b1, "R9 unmasked", irq, 1);
    wr(A_EVENT, 8'h01);
    rd(A_EVENT, rv); chk(rv == 8'h00, "R8 w1c", rv, 0);
    chk(irq == 1'b0, "R9 cleared", irq, 0);

    // R5 R6 R7 long transfer: tx closes mid-transfer, rx overflows
    wr(A_MASK, 8'h04); wr(A_CTRL, 8'h07);
    sel_lo(); run_bytes(0, 5, 2);
    rd(A_EVENT, rv); chk(rv == 8'h02, "R5 tx closed while selected", rv, 2);
    rd(A_CTRL, rv);  chk(rv == 8'h05, "R5 ready cleared", rv, 5);
    chk(irq == 1'b0, "R9 oob masked only", irq, 0);
    run_bytes(5, 15, 2); sel_hi();
    ok = 1'b1;
    for (int k = 0; k < 20; k++) ok &= (got[k] == ((k < 5) ? txd[k] : 8'hFF));
    chk(ok, "R7 ones after close", ok, 1);
    rd(A_EVENT, rv); chk(rv == 8'h07, "R6 oob event", rv, 7);
    chk(irq == 1'b1, "R9 oob irq", irq, 1);
    rd(A_RXCNT, rv); chk(rv == 8'd16, "R6 full count", rv, 16);
    rd(REG_AW'(8'h2F), rv); chk(rv == mpat(15, 2), "R6 last byte", rv, mpat(15, 2));
    rd(A_CTRL, rv); chk(rv == 8'h00, "R10 disarmed", rv, 0);

    // R6 exact fill
    wr(A_EVENT, 8'h07); wr(A_TXLEN, 8'd16); wr(A_CTRL, 8'h07);
    sel_lo(); run_bytes(0, 16, 3); sel_hi();
    rd(A_EVENT, rv); chk(rv == 8'h03, "R6 exact no oob", rv, 3);
    rd(A_RXCNT, rv); chk(rv == 8'd16, "R6 exact count", rv, 16);
    ok = 1'b1;
    for (int k = 0; k < 16; k++) ok &= (got[k] == txd[k]);
    chk(ok, "R5 all sixteen sent", ok, 1);

    // sweep: receive length, transmit length, byte count
    for (int L = 1; L <= 4; L++)
      for (int T = 1; T <= 4; T++)
        for (int n = 0; n <= 6; n++) begin
          wr(A_EVENT, 8'h07); wr(A_RXLEN, byte_t'(L)); wr(A_TXLEN, byte_t'(T));
          wr(A_CTRL, 8'h07);
          sel_lo(); run_bytes(0, n, L * 16 + T * 4 + n); sel_hi();
          cnt   = (n < L) ? n : L;
          expev = 1 | ((n >= T) ? 2 : 0) | ((n > L) ? 4 : 0);
          rd(A_EVENT, rv); chk(rv == byte_t'(expev), "R6 sweep events", rv, expev);
          rd(A_RXCNT, rv); chk(rv == byte_t'(cnt), "R10 sweep count", rv, cnt);
          rd(A_CTRL, rv);  chk(rv == ((n < T) ? 8'h06 : 8'h00), "R4 sweep flags", rv, (n < T) ? 6 : 0);
          ok = 1'b1;
          for (int k = 0; k < n; k++) ok &= (got[k] == ((k < T) ? txd[k] : 8'hFF));
          chk(ok, "R5 sweep miso", ok, 1);
          if (cnt > 0) begin
            rd(REG_AW'(8'h20 + cnt - 1), rv);
            chk(rv == mpat(cnt - 1, L * 16 + T * 4 + n), "R2 sweep data", rv, mpat(cnt - 1, L * 16 + T * 4 + n));
          end
        end

    // R3 R7 transmit closed: start refused, ones sent
    wr(A_EVENT, 8'h07); wr(A_CTRL, 8'h05);
    rd(A_CTRL, rv); chk(rv == 8'h01, "R3 refused after close", rv, 1);
    sel_lo(); run_bytes(0, 1, 5); sel_hi();
    chk(got[0] == 8'hFF, "R7 closed ones", got[0], 8'hFF);
    rd(A_RXCNT, rv); chk(rv == 8'h00, "R3 no store", rv, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule